// File: doc/BRIEF.md
# Backward-Scanning Line Reader

This block is a pipelined Wishbone read master for a falling-raster display. The image lives in a circular region of memory as a stack of lines, each a fixed number of bus words long. The block reads one frame as a run of lines. It starts at the line the memory writer finished most recently and steps toward older lines, wrapping from the bottom of the region to its top. Returned words go into a small local FIFO. Each word is tagged with an end-of-line bit and an end-of-frame bit, so the pixel-side logic downstream can check its own position against them.

Requests are issued in bursts. A burst opens when the FIFO is at least half empty. It asks for exactly as many words as the FIFO has free entries at that moment. The block releases the bus once every requested word has been acknowledged. Request-side counters follow the address walk. Separate return-side counters follow the acknowledgements and produce the tags, so acknowledgement latency and stalls never shift a tag away from its data.

Top module: `lineReader`

## Requirements
- R1: While CYC is low, CYC and STB both rise at the next edge exactly when the FIFO occupancy is at most half its depth.
- R2: A burst accepts exactly (depth minus occupancy at its start) requests, where a request is accepted when STB is high and STALL is low. STB falls after the last acceptance and stays low until CYC has dropped.
- R3: Within a line, each accepted request moves the address up by one word.
- R4: After the last word of a line is accepted, the next address is the start of the current line minus one line length.
- R5: If that step would fall below the region base, the next address is the base plus the region size minus one line length.
- R6: After the last word of the last line of a frame, and after reset, the next address is the lastLine input.
- R7: Every acknowledged word is stored in the FIFO in arrival order. fifoEol is high on the last word of each line. fifoEof is high only on the last word of the last line of a frame.
- R8: CYC stays high while any request is outstanding or STB is high. It falls at the edge that delivers the final outstanding acknowledgement.
- R9: A bus error while CYC is high drops CYC and STB at that edge. Unacknowledged words are lost, and later tags continue from the request position.
- R10: During reset CYC and STB are low and fifoValid is low.
- R11: fifoValid is high exactly while the FIFO holds data, and fifoData shows the oldest entry. A fifoRead while fifoValid is high removes that entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| regionBase | input | AW | First word address of the circular region |
| regionWords | input | AW | Region size in words, a whole number of lines |
| lineWords | input | CNTW | Words per line |
| frameLines | input | CNTW | Lines per frame |
| lastLine | input | AW | Start address of the newest completed line |
| busCyc | output | 1 | Bus cycle |
| busStb | output | 1 | Request strobe |
| busAdr | output | AW | Word address |
| busStall | input | 1 | Slave stall |
| busAck | input | 1 | Read acknowledgement |
| busErr | input | 1 | Bus error |
| busDat | input | DW | Read data |
| fifoRead | input | 1 | Consumer pop |
| fifoValid | output | 1 | FIFO holds data |
| fifoData | output | DW | Oldest word |
| fifoEol | output | 1 | Oldest word ends a line |
| fifoEof | output | 1 | Oldest word ends a frame |

## Verification
The delicate moment is an acknowledgement that lands in the same cycle as a new accepted request, or as the last accepted request of a burst. The outstanding count must then stay unchanged, and CYC must not fall too early or too late. The bench sweeps line lengths, frame heights and wrap positions with random stalls, acknowledgement gaps and latencies of up to 30 cycles. It tracks the outstanding count and the FIFO occupancy from port activity alone. At every edge it judges whether CYC had to stay, fall or rise, and it checks each address and tag against an arithmetic model of the backward walk.

// File: rtl/lineRdPkg.sv
package lineRdPkg;
  typedef struct packed {
    logic accept;
    logic ack;
    logic idle;
  } busEvents_t;
endpackage

// File: rtl/lineReaderFifo.sv
module lineReaderFifo #(
  parameter int W = 18,
  parameter int DEPTH = 8,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          valid,
  output logic [CW-1:0] fill
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;
  logic          doPush, doPop;

  assign valid  = (count != '0);
  assign doPop  = pop && valid;
  assign doPush = push && ((count != CW'(DEPTH)) || doPop);
  assign dout   = mem[rdPtr];
  assign fill   = count;

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + PW'(1);
      if (doPop)  rdPtr <= rdPtr + PW'(1);
      case ({doPush, doPop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/lineReaderCtrl.sv
module lineReaderCtrl
  import lineRdPkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int HALF = DEPTH / 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] fifoFill,
  input  logic          busStall,
  input  logic          busAck,
  input  logic          busErr,
  output logic          busCyc,
  output logic          busStb,
  output busEvents_t    ev
);
  logic          cycQ, stbQ;
  logic [CW-1:0] credits;
  logic [CW-1:0] outstanding;
  logic          accept, ack;

  assign accept = stbQ && !busStall;
  assign ack    = cycQ && busAck;

  always_ff @(posedge clk) begin
    if (rst) begin
      cycQ        <= 1'b0;
      stbQ        <= 1'b0;
      credits     <= '0;
      outstanding <= '0;
    end else if (cycQ && busErr) begin
      cycQ        <= 1'b0;
      stbQ        <= 1'b0;
      credits     <= '0;
      outstanding <= '0;
    end else if (!cycQ) begin
      outstanding <= '0;
      if (fifoFill <= CW'(HALF)) begin
        cycQ    <= 1'b1;
        stbQ    <= 1'b1;
        credits <= CW'(DEPTH) - fifoFill;
      end
    end else begin
      if (accept) begin
        credits <= credits - CW'(1);
        if (credits == CW'(1)) stbQ <= 1'b0;
      end
      case ({accept, ack})
        2'b10:   outstanding <= outstanding + CW'(1);
        2'b01:   outstanding <= outstanding - CW'(1);
        default: outstanding <= outstanding;
      endcase
      if (ack && !stbQ && outstanding == CW'(1)) cycQ <= 1'b0;
    end
  end

  assign busCyc    = cycQ;
  assign busStb    = stbQ;
  assign ev.accept = accept;
  assign ev.ack    = ack;
  assign ev.idle   = !cycQ;
endmodule

// File: rtl/lineReaderAddr.sv
module lineReaderAddr
  import lineRdPkg::*;
#(
  parameter int AW = 12,
  parameter int CNTW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  busEvents_t      ev,
  input  logic [AW-1:0]   regionBase,
  input  logic [AW-1:0]   regionWords,
  input  logic [CNTW-1:0] lineWords,
  input  logic [CNTW-1:0] frameLines,
  input  logic [AW-1:0]   lastLine,
  output logic [AW-1:0]   busAdr,
  output logic            pushEol,
  output logic            pushEof
);
  logic [CNTW-1:0] reqWord, reqLine, retWord, retLine;
  logic [AW-1:0]   lineStart, adrQ, prevStart, lineLen;
  logic            reqEol, reqEof, retEol, retEof, wrapDown;

  assign lineLen  = AW'(lineWords);
  assign reqEol   = (reqWord == lineWords - CNTW'(1));
  assign reqEof   = reqEol && (reqLine == frameLines - CNTW'(1));
  assign retEol   = (retWord == lineWords - CNTW'(1));
  assign retEof   = retEol && (retLine == frameLines - CNTW'(1));
  assign wrapDown = (lineStart - regionBase) < lineLen;

  always_comb begin
    if (wrapDown) prevStart = regionBase + regionWords - lineLen;
    else          prevStart = lineStart - lineLen;
  end

  // request side: address walk
  always_ff @(posedge clk) begin
    if (rst) begin
      reqWord   <= '0;
      reqLine   <= '0;
      lineStart <= lastLine;
      adrQ      <= lastLine;
    end else if (ev.accept) begin
      if (!reqEol) begin
        reqWord <= reqWord + CNTW'(1);
        adrQ    <= adrQ + AW'(1);
      end else if (reqEof) begin
        reqWord   <= '0;
        reqLine   <= '0;
        lineStart <= lastLine;
        adrQ      <= lastLine;
      end else begin
        reqWord   <= '0;
        reqLine   <= reqLine + CNTW'(1);
        lineStart <= prevStart;
        adrQ      <= prevStart;
      end
    end
  end

  // return side: tags follow acknowledgements
  always_ff @(posedge clk) begin
    if (rst) begin
      retWord <= '0;
      retLine <= '0;
    end else if (ev.idle) begin
      retWord <= reqWord;
      retLine <= reqLine;
    end else if (ev.ack) begin
      if (!retEol) begin
        retWord <= retWord + CNTW'(1);
      end else begin
        retWord <= '0;
        retLine <= retEof ? '0 : retLine + CNTW'(1);
      end
    end
  end

  assign busAdr  = adrQ;
  assign pushEol = retEol;
  assign pushEof = retEof;
endmodule

// File: rtl/lineReader.sv
module lineReader
  import lineRdPkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 16,
  parameter int CNTW = 8,
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   regionBase,
  input  logic [AW-1:0]   regionWords,
  input  logic [CNTW-1:0] lineWords,
  input  logic [CNTW-1:0] frameLines,
  input  logic [AW-1:0]   lastLine,
  output logic            busCyc,
  output logic            busStb,
  output logic [AW-1:0]   busAdr,
  input  logic            busStall,
  input  logic            busAck,
  input  logic            busErr,
  input  logic [DW-1:0]   busDat,
  input  logic            fifoRead,
  output logic            fifoValid,
  output logic [DW-1:0]   fifoData,
  output logic            fifoEol,
  output logic            fifoEof
);
  busEvents_t      ev;
  logic [CW-1:0]   fill;
  logic            pushEol, pushEof;
  logic [DW+1:0]   fifoOut;

  lineReaderCtrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .fifoFill(fill), .busStall(busStall),
    .busAck(busAck), .busErr(busErr), .busCyc(busCyc), .busStb(busStb), .ev(ev)
  );

  lineReaderAddr #(.AW(AW), .CNTW(CNTW)) u_addr (
    .clk(clk), .rst(rst), .ev(ev), .regionBase(regionBase),
    .regionWords(regionWords), .lineWords(lineWords), .frameLines(frameLines),
    .lastLine(lastLine), .busAdr(busAdr), .pushEol(pushEol), .pushEof(pushEof)
  );

  lineReaderFifo #(.W(DW + 2), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(ev.ack), .din({pushEof, pushEol, busDat}),
    .pop(fifoRead), .dout(fifoOut), .valid(fifoValid), .fill(fill)
  );

  assign fifoData = fifoOut[DW-1:0];
  assign fifoEol  = fifoOut[DW];
  assign fifoEof  = fifoOut[DW+1];
endmodule

// File: rtl/lineReaderChk.sv
module lineReaderChk (
  input logic clk,
  input logic rst,
  input logic busCyc,
  input logic busStb,
  input logic busAck,
  input logic busErr
);
  // R1: a burst opens with both strobes together
  a_r1_start_together: assert property (@(posedge clk) disable iff (rst)
    $rose(busCyc) |-> busStb);

  // R2: once STB falls inside a burst it stays low
  a_r2_no_restrobe: assert property (@(posedge clk) disable iff (rst)
    (busCyc && !busStb) |=> !busStb);

  // R8: CYC falls only on an acknowledgement or an error
  a_r8_cyc_release: assert property (@(posedge clk) disable iff (rst)
    (busCyc && !busAck && !busErr) |=> busCyc);

  // R9: an error ends the cycle at once
  a_r9_err_drop: assert property (@(posedge clk) disable iff (rst)
    (busCyc && busErr) |=> (!busCyc && !busStb));

  // R2: no strobe outside a cycle
  a_r2_stb_in_cyc: assert property (@(posedge clk) disable iff (rst)
    busStb |-> busCyc);
endmodule

bind lineReader lineReaderChk u_chk (
  .clk(clk), .rst(rst), .busCyc(busCyc), .busStb(busStb),
  .busAck(busAck), .busErr(busErr)
);

// File: tb/tb_lineReader.sv
module tb_lineReader;
  localparam int AW = 12, DW = 16, CNTW = 8, DEPTH = 8, HALF = DEPTH / 2;
  localparam int BASE = 64, RL = 5;

  logic clk = 1'b0, rst = 1'b1;
  logic [AW-1:0] regionBase, regionWords, lastLine;
  logic [CNTW-1:0] lineWords, frameLines;
  logic busCyc, busStb, busStall = 1'b0, busAck = 1'b0, busErr = 1'b0;
  logic [AW-1:0] busAdr;
  logic [DW-1:0] busDat = '0, fifoData;
  logic fifoRead = 1'b0, fifoValid, fifoEol, fifoEof;

  always #4 clk = ~clk;

  lineReader #(.AW(AW), .DW(DW), .CNTW(CNTW), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .regionBase(regionBase), .regionWords(regionWords),
    .lineWords(lineWords), .frameLines(frameLines), .lastLine(lastLine),
    .busCyc(busCyc), .busStb(busStb), .busAdr(busAdr), .busStall(busStall),
    .busAck(busAck), .busErr(busErr), .busDat(busDat), .fifoRead(fifoRead),
    .fifoValid(fifoValid), .fifoData(fifoData), .fifoEol(fifoEol), .fifoEof(fifoEof)
  );

  int tests = 0, fails = 0, cycleNo = 0;
  int cL, cH, cLi;
  int pendIdx[$], pendReady[$], retQ[$];
  int accIdx, occ, outSeen, burstAcc, burstTarget, lastReady, popped;
  bit cycPrev, lastAcc, lastAck, lastPop, lastErr, errMode;

  function automatic int expAddr(int k);
    int line = (k / cL) % cH;
    int off = ((cLi - line) % RL + RL) % RL;
    return BASE + off * cL + (k % cL);
  endfunction

  function automatic int dataOf(int a);
    return (a * 5 + 3) & 16'hFFFF;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cfg L=%0d H=%0d last=%0d)", req, act, exp, cL, cH, cLi);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    busStall = 0; busAck = 0; busErr = 0; fifoRead = 0;
    regionBase = AW'(BASE);
    regionWords = AW'(RL * cL);
    lineWords = CNTW'(cL);
    frameLines = CNTW'(cH);
    lastLine = AW'(BASE + cLi * cL);
    repeat (3) @(negedge clk);
    check(!busCyc && !busStb, "R10 bus idle in reset", {busCyc, busStb}, 0);
    check(!fifoValid, "R10 fifo empty in reset", fifoValid, 0);
    pendIdx.delete(); pendReady.delete(); retQ.delete();
    accIdx = 0; occ = 0; outSeen = 0; burstAcc = 0; burstTarget = 0;
    lastReady = 0; popped = 0;
    cycPrev = 0; lastAcc = 0; lastAck = 0; lastPop = 0; lastErr = 0;
    rst = 1'b0;
  endtask

  task automatic step();
    int occPrev;
    bit stall;
    @(negedge clk);
    cycleNo++;
    occPrev = occ;
    occ += int'(lastAck) - int'(lastPop);
    outSeen += int'(lastAcc) - int'(lastAck);
    burstAcc += int'(lastAcc);
    if (lastErr) outSeen = 0;
    // burst opening
    if (!cycPrev) begin
      check(busCyc == (occPrev <= HALF), "R1 start when half empty", busCyc, occPrev <= HALF);
      if (busCyc) begin
        check(busStb, "R1 stb with cyc", busStb, 1);
        burstTarget = DEPTH - occPrev;
        burstAcc = 0;
      end
    end else if (!busCyc) begin
      if (lastErr) begin
        check(!busStb, "R9 stb low after error", busStb, 0);
      end else begin
        check(outSeen == 0, "R8 release only after final ack", outSeen, 0);
        check(burstAcc == burstTarget, "R2 burst length", burstAcc, burstTarget);
      end
    end
    if (busCyc && !busStb && outSeen == 0)
      check(0, "R8 cyc held with nothing outstanding", 1, 0);
    check(fifoValid == (occ > 0), "R11 valid tracks occupancy", fifoValid, occ > 0);
    // stall and acceptance
    stall = ($urandom % 10) < 3;
    lastAcc = busStb && !stall;
    if (lastAcc) begin
      int k = accIdx;
      int line = (k / cL) % cH;
      string tag;
      if (k % cL != 0) tag = "R3 step within line";
      else if (line == 0) tag = "R6 frame restart";
      else if (((cLi - line + 1) % RL + RL) % RL == 0) tag = "R5 wrap to top";
      else tag = "R4 previous line";
      check(int'(busAdr) == expAddr(k), tag, busAdr, expAddr(k));
      pendIdx.push_back(k);
      begin
        int lat = ($urandom % 64 == 0) ? 30 : 1 + $urandom % 6;
        lastReady = (cycleNo + lat > lastReady) ? cycleNo + lat : lastReady;
      end
      pendReady.push_back(lastReady);
      accIdx++;
    end
    // acknowledgement or error
    lastAck = 0; lastErr = 0;
    if (errMode && busCyc && (outSeen > 0 || lastAcc) && $urandom % 40 == 0) begin
      lastErr = 1;
      pendIdx.delete(); pendReady.delete();
    end else if (pendIdx.size() > 0 && pendReady[0] <= cycleNo && $urandom % 4 != 0) begin
      lastAck = 1;
      busDat = DW'(dataOf(expAddr(pendIdx[0])));
      retQ.push_back(pendIdx[0]);
      void'(pendIdx.pop_front());
      void'(pendReady.pop_front());
    end
    // consumer
    lastPop = 0;
    if (fifoValid && $urandom % 2 == 0) begin
      if (retQ.size() == 0) check(0, "R7 unexpected fifo word", fifoData, -1);
      else begin
        int k = retQ.pop_front();
        bit eol = (k % cL) == cL - 1;
        bit eof = eol && ((k / cL) % cH) == cH - 1;
        check(int'(fifoData) == dataOf(expAddr(k)), "R11 fifo order", fifoData, dataOf(expAddr(k)));
        check(fifoEol == eol, "R7 end-of-line tag", fifoEol, eol);
        check(fifoEof == eof, "R7 end-of-frame tag", fifoEof, eof);
        popped++;
      end
      lastPop = 1;
    end
    cycPrev = busCyc;
    busStall = stall; busAck = lastAck; busErr = lastErr; fifoRead = lastPop;
  endtask

  task automatic runCfg(int l, int h, int li, bit em);
    cL = l; cH = h; cLi = li; errMode = em;
    doReset();
    while (popped < 120) step();
  endtask

  initial begin
    cL = 1; cH = 1; cLi = 0;
    for (int l = 1; l <= 3; l++)
      for (int h = 1; h <= 3; h++)
        for (int s = 0; s < 2; s++)
          runCfg(l, h, s * 4, ((l + h + s) % 3) == 0);
    runCfg(4, 7, 2, 0);
    runCfg(2, 6, 1, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1200000;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cycleNo, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule